// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block guards a PWM generator against fault conditions. It watches two trigger sources. The first is an external fault pin, which passes through an enable gate and a polarity select and then a fixed de-bounce filter. The second is a one-cycle compare event from an ADC comparator, which acts at once. When either source fires, the controller stops the generator by clearing its run bit. It also sends a one-cycle reset pulse to the PWM counter and asserts brake-active, which tells the output stage to drive the brake data.

A sticky fault flag records the event and drives an interrupt request while the interrupt enable is set. Software clears the flag with a write-one-clear pulse. Clearing the flag does not release the brake. The brake state is held on its own and ends only when software sets the run bit again. Register decoding, the comparator itself and the output multiplexer are outside this block.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: While `pin_en` is 0 the fault pin never causes a brake event, whatever level it holds.
- R2: With `pin_pol` = 0 a high pin level counts as a fault. With `pin_pol` = 1 a low pin level counts as a fault. The opposite level never triggers.
- R3: A qualified pin fault causes an event only when it is present at 8 consecutive rising clock edges, and the event is taken at the 8th of those edges. A shorter fault causes no event. A fault level held longer causes only one event.
- R4: A one-cycle `adc_evt` pulse causes a brake event at the edge that samples it. The pulse does this with `pin_en` at 0 and without any de-bounce delay.
- R5: At the edge that takes a brake event, `run` goes to 0 and `cnt_rst` goes to 1. `cnt_rst` stays high for exactly one cycle.
- R6: `fault_flag` is set by a brake event and stays set until a `flag_clr` pulse. If an event and `flag_clr` arrive in the same cycle, the event wins.
- R7: `irq` is high exactly while `fault_flag` is 1 and `irq_en` is 1.
- R8: `brake_active` rises with a brake event and stays high after `fault_flag` is cleared. It is released only by a `run_set` pulse, which also sets `run` at the same edge.
- R9: If `run_set` and a brake event fall in the same cycle, the event wins. `run` stays 0 and `brake_active` stays 1.
- R10: If the qualified pin level goes inactive before the de-bounce completes, the de-bounce count restarts from zero.
- R11: After reset, `run`, `brake_active`, `fault_flag`, `irq` and `cnt_rst` are all 0.
- R12: A `run_clr` pulse with no `run_set` clears `run` and leaves `brake_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 1 | External fault input, already synchronous to clk |
| pin_en | input | 1 | Enables the fault pin path |
| pin_pol | input | 1 | 0: high level is a fault, 1: low level is a fault |
| adc_evt | input | 1 | One-cycle ADC compare trigger |
| irq_en | input | 1 | Interrupt enable for the fault flag |
| run_set | input | 1 | Software write pulse that sets the run bit |
| run_clr | input | 1 | Software write pulse that clears the run bit |
| flag_clr | input | 1 | Write-one-clear pulse for the fault flag |
| run | output | 1 | Registered PWM run bit |
| cnt_rst | output | 1 | One-cycle reset pulse to the 16-bit PWM counter |
| brake_active | output | 1 | Outputs must drive the brake data |
| fault_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Fault interrupt request |

## Verification
Every registered result of this block is due one edge after the cycle that decides it. An ADC pulse or a control write shows up on `run`, `brake_active`, `fault_flag` and `cnt_rst` right after the edge that samples it. A pin fault shows up right after the 8th consecutive edge that sees the qualified level. `irq` follows the flag in the same cycle. The bench drives inputs 1 ns after a rising edge and reads outputs 1 ns after the next edge. In the length sweep it records the exact edge index at which `cnt_rst` first appears and compares that index with 8.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef struct packed {
    logic run;
    logic brake;
    logic flag;
  } brk_state_t;

  // Fault level after the enable gate and the polarity select
  function automatic logic brk_qualify(input logic pin, input logic en,
                                       input logic pol);
    return en & (pin ^ pol);
  endfunction

  // Count of consecutive qualified samples; it holds at the limit
  function automatic int unsigned brk_db_next(input int unsigned cnt,
                                              input logic q,
                                              input int unsigned lim);
    if (!q) return 0;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

  // Next control state; a fault event takes priority over software writes
  function automatic brk_state_t brk_next(input brk_state_t cur,
                                          input logic evt,
                                          input logic set_run,
                                          input logic clr_run,
                                          input logic clr_flag);
    brk_state_t n;
    n = cur;
    if (evt) begin
      n.run   = 1'b0;
      n.brake = 1'b1;
      n.flag  = 1'b1;
    end else begin
      if (set_run) begin
        n.run   = 1'b1;
        n.brake = 1'b0;
      end else if (clr_run) begin
        n.run = 1'b0;
      end
      if (clr_flag) n.flag = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/brk_pin_filter.sv
module brk_pin_filter #(
  parameter int unsigned DB_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_pin,
  input  logic pin_en,
  input  logic pin_pol,
  output logic pin_q,
  output logic pin_evt
);
  import brk_pkg::*;

  localparam int unsigned CW = $clog2(DB_LEN + 1);

  logic [CW-1:0] db_cnt;

  assign pin_q = brk_qualify(fault_pin, pin_en, pin_pol);

  // The event fires on the sample that completes DB_LEN consecutive qualified samples
  assign pin_evt = pin_q && (db_cnt == CW'(DB_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) db_cnt <= '0;
    else        db_cnt <= CW'(brk_db_next(int'(db_cnt), pin_q, DB_LEN));
  end

endmodule

// File: rtl/brk_ctrl_state.sv
module brk_ctrl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_evt,
  input  logic run_set,
  input  logic run_clr,
  input  logic flag_clr,
  input  logic irq_en,
  output logic run,
  output logic brake_active,
  output logic fault_flag,
  output logic cnt_rst,
  output logic irq
);
  import brk_pkg::*;

  brk_state_t st_q, st_d;

  assign st_d = brk_next(st_q, fault_evt, run_set, run_clr, flag_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      cnt_rst <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_rst <= fault_evt;
    end
  end

  assign run          = st_q.run;
  assign brake_active = st_q.brake;
  assign fault_flag   = st_q.flag;
  assign irq          = st_q.flag & irq_en;

endmodule

// File: rtl/pwm_brake_ctrl.sv
module pwm_brake_ctrl #(
  parameter int unsigned DB_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_pin,
  input  logic pin_en,
  input  logic pin_pol,
  input  logic adc_evt,
  input  logic irq_en,
  input  logic run_set,
  input  logic run_clr,
  input  logic flag_clr,
  output logic run,
  output logic cnt_rst,
  output logic brake_active,
  output logic fault_flag,
  output logic irq
);

  logic pin_q;
  logic pin_evt;
  logic fault_evt;

  brk_pin_filter #(.DB_LEN(DB_LEN)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_pin (fault_pin),
    .pin_en    (pin_en),
    .pin_pol   (pin_pol),
    .pin_q     (pin_q),
    .pin_evt   (pin_evt)
  );

  assign fault_evt = pin_evt | adc_evt;

  brk_ctrl_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_evt    (fault_evt),
    .run_set      (run_set),
    .run_clr      (run_clr),
    .flag_clr     (flag_clr),
    .irq_en       (irq_en),
    .run          (run),
    .brake_active (brake_active),
    .fault_flag   (fault_flag),
    .cnt_rst      (cnt_rst),
    .irq          (irq)
  );

endmodule

// File: rtl/brk_checker.sv
module brk_checker #(
  parameter int unsigned DB_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pin_en,
  input logic adc_evt,
  input logic run_set,
  input logic flag_clr,
  input logic pin_q,
  input logic pin_evt,
  input logic fault_evt,
  input logic run,
  input logic cnt_rst,
  input logic brake_active,
  input logic fault_flag
);
  localparam int unsigned CW = $clog2(DB_LEN + 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= '0;
    else if (!pin_q)       seen <= '0;
    else if (seen < CW'(DB_LEN)) seen <= seen + 1'b1;
  end

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> !pin_evt); // R1
  AST_DEBOUNCE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |-> (seen == CW'(DB_LEN - 1))); // R3
  AST_ADC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_evt |-> fault_evt); // R4
  AST_EVT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!run && cnt_rst && brake_active)); // R5
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst && !fault_evt) |=> !cnt_rst); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> fault_flag); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fault_evt) |=> !fault_flag); // R6
  AST_BRAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_active && !run_set) |=> brake_active); // R8
  AST_BRAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_set && !fault_evt) |=> (run && !brake_active)); // R8
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_set && fault_evt) |=> (!run && brake_active)); // R9

endmodule

bind pwm_brake_ctrl brk_checker #(.DB_LEN(DB_LEN)) u_brk_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_en       (pin_en),
  .adc_evt      (adc_evt),
  .run_set      (run_set),
  .flag_clr     (flag_clr),
  .pin_q        (pin_q),
  .pin_evt      (pin_evt),
  .fault_evt    (fault_evt),
  .run          (run),
  .cnt_rst      (cnt_rst),
  .brake_active (brake_active),
  .fault_flag   (fault_flag)
);

// File: tb/test_pwm_brake_ctrl.sv
`timescale 1ns/1ps
module test_pwm_brake_ctrl;

  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_pin = 1'b0, pin_en = 1'b0, pin_pol = 1'b0, adc_evt = 1'b0;
  logic irq_en = 1'b0, run_set = 1'b0, run_clr = 1'b0, flag_clr = 1'b0;
  logic run, cnt_rst, brake_active, fault_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_brake_ctrl #(.DB_LEN(DB)) i_pwm_brake_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .pin_en(pin_en),
    .pin_pol(pin_pol), .adc_evt(adc_evt), .irq_en(irq_en),
    .run_set(run_set), .run_clr(run_clr), .flag_clr(flag_clr),
    .run(run), .cnt_rst(cnt_rst), .brake_active(brake_active),
    .fault_flag(fault_flag), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pin goes inactive, flag cleared, brake released, run set
  task automatic rearm();
    fault_pin = pin_pol;
    adc_evt   = 1'b0;
    tick();
    flag_clr = 1'b1;
    run_set  = 1'b1;
    tick();
    flag_clr = 1'b0;
    run_set  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk("R11 run", run, 0);
    chk("R11 brake", brake_active, 0);
    chk("R11 flag", fault_flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 cnt_rst", cnt_rst, 0);
    rst_n = 1'b1;
    tick();

    // R1 R2 enable and polarity table
    for (int en = 0; en < 2; en++)
      for (int pol = 0; pol < 2; pol++)
        for (int lvl = 0; lvl < 2; lvl++) begin
          pin_en  = en[0];
          pin_pol = pol[0];
          rearm();
          fault_pin = lvl[0];
          repeat (DB + 4) tick();
          chk(en == 0 ? "R1 gated pin" : "R2 polarity", brake_active,
              (en == 1 && lvl != pol) ? 1 : 0);
          chk("R2 run", run, (en == 1 && lvl != pol) ? 0 : 1);
        end

    // R3 R5 length sweep with polarity 0
    pin_en  = 1'b1;
    pin_pol = 1'b0;
    for (int len = 1; len <= DB + 6; len++) begin
      int first_k;
      int pulses;
      int ev;
      rearm();
      first_k = 0;
      pulses  = 0;
      ev = (len >= DB) ? 1 : 0;
      fault_pin = 1'b1;
      for (int k = 1; k <= len; k++) begin
        tick();
        if (cnt_rst) begin
          pulses++;
          if (first_k == 0) first_k = k;
          if (k == DB) chk("R5 run low with cnt_rst", run, 0);
        end
      end
      fault_pin = 1'b0;
      tick();
      if (cnt_rst) pulses++;
      chk("R3 event edge", first_k, ev ? DB : 0);
      chk("R3 single event", pulses, ev);
      chk("R5 run", run, ev ? 0 : 1);
      chk("R8 brake", brake_active, ev);
    end

    // R10 de-bounce restart: 7 on, 1 off, 7 on
    rearm();
    fault_pin = 1'b1;
    repeat (DB - 1) tick();
    fault_pin = 1'b0;
    tick();
    fault_pin = 1'b1;
    repeat (DB - 1) tick();
    chk("R10 restart no brake", brake_active, 0);
    tick();
    chk("R10 brake after full run", brake_active, 1);
    fault_pin = 1'b0;

    // R4 R5 R6 R7 ADC path with pin disabled and irq enabled
    pin_en = 1'b0;
    rearm();
    irq_en = 1'b1;
    tick();
    chk("R7 irq idle", irq, 0);
    adc_evt = 1'b1;
    tick();
    adc_evt = 1'b0;
    chk("R4 adc brake", brake_active, 1);
    chk("R5 adc run", run, 0);
    chk("R5 adc cnt_rst", cnt_rst, 1);
    chk("R6 flag set", fault_flag, 1);
    chk("R7 irq", irq, 1);
    tick();
    chk("R5 cnt_rst one cycle", cnt_rst, 0);
    irq_en = 1'b0;
    #1;
    chk("R7 irq masked", irq, 0);
    irq_en = 1'b1;

    // R6 R8 flag clear keeps brake
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R6 flag cleared", fault_flag, 0);
    chk("R7 irq after clear", irq, 0);
    chk("R8 brake held", brake_active, 1);
    repeat (3) tick();
    chk("R8 brake still held", brake_active, 1);
    run_set = 1'b1;
    tick();
    run_set = 1'b0;
    chk("R8 release", brake_active, 0);
    chk("R8 run set", run, 1);

    // R6 event wins over flag clear
    flag_clr = 1'b1;
    adc_evt  = 1'b1;
    tick();
    flag_clr = 1'b0;
    adc_evt  = 1'b0;
    chk("R6 event over clear", fault_flag, 1);

    // R9 run_set with event
    rearm();
    run_set = 1'b1;
    adc_evt = 1'b1;
    tick();
    run_set = 1'b0;
    adc_evt = 1'b0;
    chk("R9 run stays low", run, 0);
    chk("R9 brake stays", brake_active, 1);

    // R12 run_clr leaves brake alone
    rearm();
    run_clr = 1'b1;
    tick();
    run_clr = 1'b0;
    chk("R12 run cleared", run, 0);
    chk("R12 brake unchanged", brake_active, 0);
    adc_evt = 1'b1;
    tick();
    adc_evt = 1'b0;
    run_clr = 1'b1;
    tick();
    run_clr = 1'b0;
    chk("R12 brake kept", brake_active, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule